// File: doc/BRIEF.md
# Sector Hamming Parity and Single-Bit Check Engine

This block builds a 24-bit Hamming-style check word while the bytes of one flash sector stream past it. Every data bit is identified by a 12-bit index, made of the byte address (upper nine bits) and the bit lane within the byte (lower three bits). For each index bit the engine keeps two running parities. The "set" parity covers the data bits whose index has that bit at one. The "clear" parity covers the rest. A start pulse opens a sector. The block then accepts bytes until the sector count is reached, and raises a done flag.

The check word is the bit inverse of {set half, clear half}. Because of the inversion, a fully erased sector (all bytes 0xFF) produces 0xFFFFFF, which is what erased spare area reads back as. The word is stored with its least significant byte first. On read-back the caller presents the stored word. The block XORs it with the freshly computed word and sorts the result into one of four outcomes: clean, one flipped data bit (with byte offset and flip mask), one flipped bit in the check word itself, or uncorrectable.

Top module: `hecc_engine`

## Requirements
- R1: After reset, `done_o` is 0 and `code_o` is 0xFFFFFF, because all parities are zero.
- R2: For data bit b (0..7) of the byte at offset a, let the index be i = {a[8:0], b[2:0]}. For each k in 0..11, the bit is XORed into set parity k when i[k] is 1, and into clear parity k when i[k] is 0. `code_o` equals ~{set[11:0], clear[11:0]}, so the set half occupies `code_o[23:12]`.
- R3: A sector of all-0xFF bytes yields `code_o` = 0xFFFFFF, and with `stored_code_i` = 0xFFFFFF the status is clean.
- R4: `done_o` rises in the cycle after the clock edge that accepts the SECTOR_BYTES-th byte. It then holds, and `code_o` holds, until the next start; bytes offered while done are ignored.
- R5: A `start_i` pulse clears every parity, the byte count and `done_o` at that edge, which discards a partial sector. A byte offered in the same cycle is dropped.
- R6: Let d = `code_o` XOR `stored_code_i`. The status is encoded 0 clean, 1 data bit error, 2 check-word bit error, 3 uncorrectable. If d is 0, `status_o` is 0, and `err_byte_o` and `err_mask_o` are 0.
- R7: If (d[23:12] XOR d[11:0]) is 0xFFF and d[23:15] < SECTOR_BYTES, `status_o` is 1, `err_byte_o` = d[23:15], and `err_mask_o` = 1 << d[14:12].
- R8: If d has exactly one bit set, `status_o` is 2 and `err_mask_o` is 0.
- R9: If (d[23:12] XOR d[11:0]) is 0xFFF but d[23:15] >= SECTOR_BYTES, `status_o` is 3.
- R10: Any other nonzero d, for example two flipped data bits, gives `status_o` = 3 with `err_byte_o` and `err_mask_o` equal to 0.
- R11: In a cycle with `byte_valid_i` low and `start_i` low, the parities and the byte count do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new sector, discarding any partial one |
| byte_valid_i | input | 1 | `byte_i` carries a sector byte this cycle |
| byte_i | input | 8 | Sector data byte, in address order |
| stored_code_i | input | 24 | Check word read back from the spare area |
| code_o | output | 24 | Computed check word, least significant byte stored first |
| done_o | output | 1 | Whole sector accepted; results are final |
| status_o | output | 2 | 0 clean, 1 data fix, 2 check-word bit, 3 uncorrectable |
| err_byte_o | output | 9 | Byte offset of the bit to flip (status 1 only) |
| err_mask_o | output | 8 | Bit mask to XOR into that byte (status 1 only) |

## Verification
The accumulator is driven with an erased sector, with an arithmetic byte pattern containing idle gaps, and with an aborted partial sector. A bench model recomputes the parities bit by bit from the index definition and compares them every clock. Together these runs separate the inversion and packing from lane and address parity mistakes. Classification is tried with stored words perturbed by single data bit flips at the first and last offsets and at a middle offset, with single check-word bit flips in each half, and with a double flip. These distinguish the four outcomes and the offset and mask extraction. A second instance with a 256-byte sector checks that a syndrome pointing past the sector is rejected.

// File: rtl/hecc_pkg.sv
// Shared widths, status encoding and helper for the sector check engine.
package hecc_pkg;
    localparam int HALF_W = 12;              // one parity half
    localparam int CODE_W = 2 * HALF_W;      // full check word
    localparam int LANE_W = 3;               // bit-in-byte index width
    localparam int ADDR_W = HALF_W - LANE_W; // byte offset field width

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_DATA  = 2'd1,
        ST_CODE  = 2'd2,
        ST_BAD   = 2'd3
    } hecc_status_e;

    // Mask of byte lanes whose lane number has bit k set.
    function automatic logic [7:0] lane_sel(input int k);
        logic [7:0] m;
        for (int j = 0; j < 8; j++) begin
            m[j] = ((j >> k) & 1) != 0;
        end
        return m;
    endfunction
endpackage

// File: rtl/hecc_accum.sv
// Running parity accumulator.
// Keeps set/clear parity halves over one sector of streamed bytes.
// Assumes SECTOR_BYTES <= 2**ADDR_W; bytes arrive in address order.
module hecc_accum
    import hecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    output logic [HALF_W-1:0] set_o,
    output logic [HALF_W-1:0] clr_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(SECTOR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SECTOR_BYTES - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic [HALF_W-1:0] set_q, clr_q;
    logic [HALF_W-1:0] set_c, clr_c;
    logic [ADDR_W-1:0] addr;
    logic              byte_par;
    logic              take;

    assign addr     = ADDR_W'(cnt_q);
    assign byte_par = ^byte_i;
    assign take     = byte_valid_i && !done_q;

    // Lane contributions: parity over the lanes selected by each lane-index bit.
    for (genvar k = 0; k < LANE_W; k++) begin : g_lane
        localparam logic [7:0] SEL = lane_sel(k);
        assign set_c[k] = ^(byte_i & SEL);
        assign clr_c[k] = ^(byte_i & ~SEL);
    end

    // Address contributions: the whole-byte parity steered by each address bit.
    for (genvar k = 0; k < ADDR_W; k++) begin : g_addr
        assign set_c[LANE_W+k] = addr[k] & byte_par;
        assign clr_c[LANE_W+k] = ~addr[k] & byte_par;
    end

    // Accumulate accepted bytes; start or reset clears the sector state.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
            set_q  <= '0;
            clr_q  <= '0;
        end else if (take) begin
            set_q  <= set_q ^ set_c;
            clr_q  <= clr_q ^ clr_c;
            cnt_q  <= cnt_q + 1'b1;
            done_q <= (cnt_q == LAST);
        end
    end

    assign set_o  = set_q;
    assign clr_o  = clr_q;
    assign done_o = done_q;

    p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_q && set_q == '0 && clr_q == '0 && cnt_q == '0));
    p_done_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !start_i) |=> (done_q && $stable(set_q) && $stable(clr_q)));
    p_done_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(byte_valid_i));
    p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !byte_valid_i) |=> ($stable(set_q) && $stable(clr_q) && $stable(cnt_q)));
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SECTOR_BYTES));
endmodule

// File: rtl/hecc_classify.sv
// Syndrome classifier.
// Compares computed and stored check words and decides the outcome.
// Purely combinational; assumes both words use the same inverted packing.
module hecc_classify
    import hecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0] calc_i,
    input  logic [CODE_W-1:0] stored_i,
    output logic [1:0]        status_o,
    output logic [ADDR_W-1:0] err_byte_o,
    output logic [7:0]        err_mask_o
);
    logic [CODE_W-1:0] diff;
    logic              mirror;
    logic              in_range;
    logic              single;

    assign diff     = calc_i ^ stored_i;
    assign mirror   = (diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0]) == {HALF_W{1'b1}};
    assign in_range = 32'(diff[CODE_W-1:HALF_W+LANE_W]) < SECTOR_BYTES;
    assign single   = $onehot(diff);

    // Decide the outcome and the flip location from the syndrome.
    always_comb begin
        status_o   = ST_CLEAN;
        err_byte_o = '0;
        err_mask_o = '0;
        if (diff == '0) begin
            status_o = ST_CLEAN;
        end else if (mirror && in_range) begin
            status_o   = ST_DATA;
            err_byte_o = diff[CODE_W-1:HALF_W+LANE_W];
            err_mask_o = 8'(1) << diff[HALF_W+LANE_W-1:HALF_W];
        end else if (mirror) begin
            status_o = ST_BAD;
        end else if (single) begin
            status_o = ST_CODE;
        end else begin
            status_o = ST_BAD;
        end
    end
endmodule

// File: rtl/hecc_engine.sv
// Sector check engine top.
// Joins the parity accumulator and the classifier; forms the inverted,
// packed check word {set half, clear half}. Results are final when done_o.
module hecc_engine
    import hecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        byte_valid_i,
    input  logic [7:0]  byte_i,
    input  logic [23:0] stored_code_i,
    output logic [23:0] code_o,
    output logic        done_o,
    output logic [1:0]  status_o,
    output logic [8:0]  err_byte_o,
    output logic [7:0]  err_mask_o
);
    logic [HALF_W-1:0] set_h, clr_h;

    hecc_accum #(.SECTOR_BYTES(SECTOR_BYTES)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .byte_valid_i(byte_valid_i),
        .byte_i      (byte_i),
        .set_o       (set_h),
        .clr_o       (clr_h),
        .done_o      (done_o)
    );

    // Inversion makes an erased sector's word read back as all ones.
    assign code_o = ~{set_h, clr_h};

    hecc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_class (
        .calc_i    (code_o),
        .stored_i  (stored_code_i),
        .status_o  (status_o),
        .err_byte_o(err_byte_o),
        .err_mask_o(err_mask_o)
    );

    p_clean_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == ST_CLEAN) |-> (code_o == stored_code_i && err_mask_o == '0));
    p_data_fix_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == ST_DATA) |-> ($onehot(err_mask_o) && 32'(err_byte_o) < SECTOR_BYTES));
    p_code_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == ST_CODE) |-> ($countones(code_o ^ stored_code_i) == 1 && err_mask_o == '0));
    p_bad_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == ST_BAD) |-> (err_mask_o == '0 && err_byte_o == '0));
endmodule

// File: tb/hecc_engine_bench.sv
`timescale 1ns/1ps
// Bench: behavioural per-bit parity model compared every clock, plus
// directed syndrome cases on a 512-byte and a 256-byte instance.
module hecc_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [23:0] stored_code_i = 24'hFFFFFF;
    logic [23:0] stored2 = 24'hFFFFFF;
    logic [23:0] code_o, code2;
    logic        done_o, done2;
    logic [1:0]  status_o, status2;
    logic [8:0]  err_byte_o, err_byte2;
    logic [7:0]  err_mask_o, err_mask2;

    int vectors = 0;
    int miscompares = 0;

    // model state
    int         m_cnt = 0;
    bit         m_done = 0;
    bit [11:0]  m_set = '0;
    bit [11:0]  m_clr = '0;

    always #2.5 clk = ~clk;

    hecc_engine u_hecc_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
        .byte_i(byte_i), .stored_code_i(stored_code_i), .code_o(code_o),
        .done_o(done_o), .status_o(status_o), .err_byte_o(err_byte_o),
        .err_mask_o(err_mask_o)
    );

    hecc_engine #(.SECTOR_BYTES(256)) u_small (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
        .byte_i(byte_i), .stored_code_i(stored2), .code_o(code2),
        .done_o(done2), .status_o(status2), .err_byte_o(err_byte2),
        .err_mask_o(err_mask2)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] model_code();
        return ~{m_set, m_clr};
    endfunction

    // One clock: drive at negedge, update model after the edge, compare at next negedge.
    task automatic step(input bit st, input bit vld, input logic [7:0] d);
        start_i = st; byte_valid_i = vld; byte_i = d;
        @(posedge clk);
        if (st) begin
            m_cnt = 0; m_done = 0; m_set = '0; m_clr = '0;
        end else if (vld && !m_done) begin
            for (int b = 0; b < 8; b++) begin
                if (d[b]) begin
                    int idx;
                    idx = m_cnt * 8 + b;
                    for (int k = 0; k < 12; k++) begin
                        if ((idx >> k) & 1) m_set[k] = ~m_set[k];
                        else                m_clr[k] = ~m_clr[k];
                    end
                end
            end
            m_cnt++;
            if (m_cnt == 512) m_done = 1;
        end
        @(negedge clk);
        check("R2 code_o", code_o, model_code());
        check("R4 done_o", done_o, m_done);
    endtask

    function automatic logic [7:0] pat(int seed, int i);
        return 8'((i * seed) ^ (i >> 3) ^ 8'h5A);
    endfunction

    // Syndrome for a flipped data bit: set half gets the index, clear half its complement.
    function automatic logic [23:0] data_syn(int a, int b);
        logic [11:0] idx;
        idx = 12'(a * 8 + b);
        return {idx, ~idx};
    endfunction

    task automatic try_main(input string req, input logic [23:0] syn,
                            input logic [1:0] st, input logic [8:0] by, input logic [7:0] mk);
        stored_code_i = code_o ^ syn;
        @(posedge clk); @(negedge clk);
        check({req, " status"}, status_o, st);
        check({req, " byte"}, err_byte_o, by);
        check({req, " mask"}, err_mask_o, mk);
    endtask

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 done after reset", done_o, 1'b0);
        check("R1 code after reset", code_o, 24'hFFFFFF);

        // R3, R11: erased sector with idle gaps
        for (int i = 0; i < 512; i++) begin
            step(0, 1, 8'hFF);
            if (i % 97 == 5) step(0, 0, 8'h13); // R11 idle cycle with junk data
        end
        check("R3 erased code", code_o, 24'hFFFFFF);
        stored_code_i = 24'hFFFFFF;
        @(posedge clk); @(negedge clk);
        check("R3 erased status clean", status_o, 2'd0);
        // R4: bytes after done are ignored
        for (int i = 0; i < 3; i++) step(0, 1, 8'h01);

        // R5: partial sector discarded by a new start
        step(1, 0, 8'h00);
        for (int i = 0; i < 100; i++) step(0, 1, pat(11, i));
        step(1, 1, 8'hA5); // R5 same-cycle byte dropped
        check("R5 cleared code", code_o, 24'hFFFFFF);

        // R2: patterned sector with gaps
        for (int i = 0; i < 512; i++) begin
            step(0, 1, pat(37, i));
            if (i % 61 == 0) step(0, 0, 8'hEE);
        end
        check("R4 done at sector end", done_o, 1'b1);

        try_main("R6 clean", 24'h0, 2'd0, 9'd0, 8'h00);
        try_main("R7 mid", data_syn(300, 5), 2'd1, 9'd300, 8'h20);
        try_main("R7 first", data_syn(0, 0), 2'd1, 9'd0, 8'h01);
        try_main("R7 last", data_syn(511, 7), 2'd1, 9'd511, 8'h80);
        try_main("R8 low", 24'h000001, 2'd2, 9'd0, 8'h00);
        try_main("R8 mid", 24'h002000, 2'd2, 9'd0, 8'h00);
        try_main("R8 top", 24'h800000, 2'd2, 9'd0, 8'h00);
        try_main("R10 double", data_syn(3, 1) ^ data_syn(200, 6), 2'd3, 9'd0, 8'h00);
        try_main("R10 two code bits", 24'h000003, 2'd3, 9'd0, 8'h00);

        // R9: small instance, syndrome pointing beyond 256 bytes
        check("R4 small done", done2, 1'b1);
        stored2 = code2 ^ data_syn(300, 2);
        @(posedge clk); @(negedge clk);
        check("R9 out of range status", status2, 2'd3);
        check("R9 out of range mask", err_mask2, 8'h00);
        stored2 = code2 ^ data_syn(200, 4);
        @(posedge clk); @(negedge clk);
        check("R7 small in range status", status2, 2'd1);
        check("R7 small byte", err_byte2, 9'd200);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule